// File: doc/BRIEF.md
# Pipelined Square Matrix Multiplier Grid

The block multiplies two square N×N matrices of unsigned W-bit integers on an N×N grid of multiply-accumulate cells. Cell (i,j) owns product element C[i][j]. A pair of matrices enters as N beats. On beat k the west edge receives column k of A, which each row carries east over its links. The north edge receives row k of B, which each column carries south. All N² cells therefore see their two operands on the same cycle and complete one multiply-accumulate per accepted beat. A pair is finished N beats after its first beat, not 2N-1.

On the edge that accepts the last beat of a pair, every cell's final sum is copied into a drain bank. The cell accumulators are then free for the next pair on the very next cycle. The drain bank moves the rows south one step per cycle and emits the bottom row first. The emission rate of one full row per cycle matches the N-beat input cadence, so pairs can be streamed back to back with no drain gap. Input beats use a valid/ready handshake. A start flag restarts a pair. Idle cycles (bubbles) may appear anywhere inside a pair.

Top module: `xmesh_matmul`

## Requirements
- R1: While reset is asserted out_valid_o is low and every accumulator is zero. in_ready_o is high from the first clock edge after reset is released.
- R2: For each pair the block delivers the exact unsigned product C = A×B. It accepts A[i][k] on lane i of a_col_i (bits i*W upward) and B[k][j] on lane j of b_row_i on the k-th beat of the pair. Results are ACC_W = 2W+ceil(log2 N) bits wide and do not overflow even when every operand is at its maximum value.
- R3: The first result row of a pair is presented in the cycle right after the clock edge that accepts the pair's N-th beat.
- R4: The N result rows of a pair leave on consecutive cycles, from row N-1 down to row 0. out_row_o gives the row index, lane j of out_data_o (bits j*ACC_W upward) holds column j, and out_last_o is high only with row 0.
- R5: A new pair may begin on the beat after the previous pair's last beat. For k back-to-back pairs whose first beat is accepted at edge p, the final out_last_o is seen N-2 cycles after edge p+kN, with no bubble in the output stream.
- R6: A cycle with no accepted beat (in_valid_i low) changes no accumulator, whatever the operand inputs carry. Bubbles inside a pair do not alter its result.
- R7: A beat with in_first_i high discards any partial sums of an unfinished pair and counts as beat 0 of a new pair. The abandoned pair produces no output.
- R8: After a pair completes, the next accepted beat is beat 0 of a new pair even if in_first_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand beat present |
| in_ready_o | output | 1 | Block accepts beats |
| in_first_i | input | 1 | Beat starts a new pair |
| a_col_i | input | N*W | One column of A, lane i = row i |
| b_row_i | input | N*W | One row of B, lane j = column j |
| out_valid_o | output | 1 | Result row present |
| out_row_o | output | max(1,ceil(log2 N)) | Index of the result row |
| out_data_o | output | N*ACC_W | Result row, lane j = column j |
| out_last_o | output | 1 | Final row of a product |

## Verification
The hardest case to reach is the capture of a new pair in the same cycle that the drain bank shows the last row of the previous product. A late capture would corrupt that row, and an early one would drop it. The bench reaches this case by streaming several pairs with no idle beat between them and checking every row as well as the cycle of the final out_last_o. It also places bubbles carrying junk operands inside pairs, and it abandons a pair part-way through, to show that neither disturbs the accumulators.

// File: rtl/xmesh_pkg.sv
package xmesh_pkg;
  function automatic int acc_width(input int n, input int w);
    return 2 * w + $clog2(n);
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xmesh_pe.sv
module xmesh_pe #(
  parameter int W  = 8,
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic          clr_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [AW-1:0] sum_nxt_o,
  output logic [AW-1:0] acc_o
);
  logic [2*W-1:0] prod;
  logic [AW-1:0]  acc_q;

  assign prod      = a_i * b_i;
  assign sum_nxt_o = (clr_i ? '0 : acc_q) + AW'(prod);
  assign acc_o     = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (beat_i) acc_q <= sum_nxt_o;
  end
endmodule

// File: rtl/xmesh_seq.sv
module xmesh_seq #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic beat_i,
  input  logic first_i,
  output logic clr_o,
  output logic done_o,
  output logic ready_o
);
  import xmesh_pkg::*;
  localparam int CW = idx_width(N);

  logic [CW-1:0] cnt_q, pos;
  logic          last_beat, ready_q;

  // a flagged beat is always position 0
  assign pos       = first_i ? '0 : cnt_q;
  assign last_beat = (pos == CW'(N - 1));
  assign clr_o     = (pos == '0);
  assign done_o    = beat_i & last_beat;
  assign ready_o   = ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (beat_i) cnt_q <= last_beat ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/xmesh_drain.sv
module xmesh_drain #(
  parameter int N  = 4,
  parameter int AW = 18
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [N*N*AW-1:0]   sums_i,
  output logic                valid_o,
  output logic [xmesh_pkg::idx_width(N)-1:0] row_o,
  output logic [N*AW-1:0]     data_o,
  output logic                last_o
);
  import xmesh_pkg::*;
  localparam int RW = idx_width(N);
  localparam int LW = N * AW;

  logic [LW-1:0] snap_q [N];
  logic [RW-1:0] cnt_q;
  logic          vld_q, at_end;

  assign at_end = (cnt_q == RW'(N - 1));

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    logic [LW-1:0] up;
    if (gi == 0) begin : g_top
      assign up = '0;
    end else begin : g_mid
      assign up = snap_q[gi-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     snap_q[gi] <= '0;
      else if (cap_i)  snap_q[gi] <= sums_i[gi*LW +: LW];
      else if (vld_q)  snap_q[gi] <= up;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else if (cap_i) begin
      vld_q <= 1'b1;
      cnt_q <= '0;
    end else if (vld_q) begin
      vld_q <= !at_end;
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign valid_o = vld_q;
  assign row_o   = RW'(N - 1) - cnt_q;
  assign data_o  = snap_q[N-1];
  assign last_o  = vld_q & at_end;
endmodule

// File: rtl/xmesh_matmul.sv
module xmesh_matmul #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         in_valid_i,
  output logic                                         in_ready_o,
  input  logic                                         in_first_i,
  input  logic [N*W-1:0]                               a_col_i,
  input  logic [N*W-1:0]                               b_row_i,
  output logic                                         out_valid_o,
  output logic [xmesh_pkg::idx_width(N)-1:0]           out_row_o,
  output logic [N*xmesh_pkg::acc_width(N, W)-1:0]      out_data_o,
  output logic                                         out_last_o
);
  import xmesh_pkg::*;
  localparam int AW = acc_width(N, W);

  logic beat, clr, done;
  logic [W-1:0]      a_lnk [N][N];
  logic [W-1:0]      b_lnk [N][N];
  logic [N*N*AW-1:0] sum_flat, acc_flat;

  assign beat = in_valid_i & in_ready_o;

  xmesh_seq #(.N(N)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (beat),
    .first_i(in_first_i),
    .clr_o  (clr),
    .done_o (done),
    .ready_o(in_ready_o)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_r
    for (genvar gj = 0; gj < N; gj++) begin : g_c
      // A travels east along the row, B south along the column
      if (gj == 0) begin : g_aw
        assign a_lnk[gi][gj] = a_col_i[gi*W +: W];
      end else begin : g_ai
        assign a_lnk[gi][gj] = a_lnk[gi][gj-1];
      end
      if (gi == 0) begin : g_bn
        assign b_lnk[gi][gj] = b_row_i[gj*W +: W];
      end else begin : g_bi
        assign b_lnk[gi][gj] = b_lnk[gi-1][gj];
      end

      xmesh_pe #(.W(W), .AW(AW)) u_pe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .beat_i   (beat),
        .clr_i    (clr),
        .a_i      (a_lnk[gi][gj]),
        .b_i      (b_lnk[gi][gj]),
        .sum_nxt_o(sum_flat[(gi*N+gj)*AW +: AW]),
        .acc_o    (acc_flat[(gi*N+gj)*AW +: AW])
      );
    end
  end

  xmesh_drain #(.N(N), .AW(AW)) u_drain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (done),
    .sums_i (sum_flat),
    .valid_o(out_valid_o),
    .row_o  (out_row_o),
    .data_o (out_data_o),
    .last_o (out_last_o)
  );
endmodule

// File: rtl/xmesh_matmul_chk.sv
module xmesh_matmul_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic                                            clk_i,
  input logic                                            rst_ni,
  input logic                                            in_valid_i,
  input logic                                            in_ready_o,
  input logic                                            out_valid_o,
  input logic [xmesh_pkg::idx_width(N)-1:0]              out_row_o,
  input logic                                            out_last_o,
  input logic [N*N*xmesh_pkg::acc_width(N, W)-1:0]       acc_flat_i
);
  import xmesh_pkg::*;
  localparam int RW = idx_width(N);

  // R4
  last_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (out_valid_o && out_row_o == '0));

  // R4
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> (out_valid_o && out_row_o == RW'($past(out_row_o) - 1'b1)));

  // R4
  first_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (out_row_o == RW'(N - 1)));

  // R3
  result_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o));

  // R6
  bubble_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) |=> $stable(acc_flat_i));
endmodule

bind xmesh_matmul xmesh_matmul_chk #(.N(N), .W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_row_o  (out_row_o),
  .out_last_o (out_last_o),
  .acc_flat_i (acc_flat)
);

// File: tb/sim_xmesh_matmul.sv
`timescale 1ns/1ps
module sim_xmesh_matmul;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 2 * W + 2;
  localparam int RW = 2;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_first_i = 1'b0;
  logic [N*W-1:0]  a_col_i = '0;
  logic [N*W-1:0]  b_row_i = '0;
  logic            in_ready_o, out_valid_o, out_last_o;
  logic [RW-1:0]   out_row_o;
  logic [N*AW-1:0] out_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  int ma [N][N];
  int mb [N][N];
  logic [N*AW-1:0] exp_d [$];
  int              exp_r [$];

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  xmesh_matmul #(.N(N), .W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_first_i(in_first_i), .a_col_i(a_col_i), .b_row_i(b_row_i),
    .out_valid_o(out_valid_o), .out_row_o(out_row_o), .out_data_o(out_data_o),
    .out_last_o(out_last_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compares every streamed row with the reference queue (R2, R4, R7)
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R7", "unexpected result row", 128'(out_row_o), 128'hff);
      end else begin
        logic [N*AW-1:0] ed;
        int er;
        ed = exp_d.pop_front();
        er = exp_r.pop_front();
        chk(out_data_o == ed, "R2", "result row data", 128'(out_data_o), 128'(ed));
        chk(out_row_o == RW'(er), "R4", "row index", 128'(out_row_o), 128'(er));
        chk(out_last_o == (er == 0), "R4", "last flag", 128'(out_last_o), 128'(er == 0));
      end
      if (out_last_o) last_cyc = cyc;
    end
  end

  task automatic fill_rand();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = $urandom_range(0, 255);
        mb[i][j] = $urandom_range(0, 255);
      end
  endtask

  task automatic push_expected();
    for (int r = N - 1; r >= 0; r--) begin
      logic [N*AW-1:0] row;
      for (int j = 0; j < N; j++) begin
        int s = 0;
        for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][j];
        row[j*AW +: AW] = AW'(s);
      end
      exp_d.push_back(row);
      exp_r.push_back(r);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      in_valid_i = 1'b0;
      in_first_i = 1'($urandom_range(0, 1));
      a_col_i    = N*W'($urandom);
      b_row_i    = N*W'($urandom);
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic beat(input int k, input bit first);
    for (int i = 0; i < N; i++) begin
      a_col_i[i*W +: W] = W'(ma[i][k]);
      b_row_i[i*W +: W] = W'(mb[k][i]);
    end
    in_valid_i = 1'b1;
    in_first_i = first;
    @(posedge clk_i);
  endtask

  task automatic send_pair(input int gap, input bit use_first, input bit chk_lat);
    for (int k = 0; k < N; k++) begin
      beat(k, use_first && k == 0);
      if (k == N - 1) push_expected();
      @(negedge clk_i);
      if (k == N - 1 && chk_lat) begin
        // R3 first row visible right after the N-th beat's edge
        chk(out_valid_o == 1'b1, "R3", "valid after last beat", 128'(out_valid_o), 128'd1);
        chk(out_row_o == RW'(N - 1), "R3", "first row index", 128'(out_row_o), 128'(N - 1));
      end
      in_valid_i = 1'b0;
      if (gap > 0 && k < N - 1) idle(gap);
    end
  endtask

  task automatic drain_wait();
    idle(N + 2);
    chk(exp_d.size() == 0, "R4", "rows outstanding", 128'(exp_d.size()), 128'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R1", "valid in reset", 128'(out_valid_o), 128'd0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", "ready after reset", 128'(in_ready_o), 128'd1);
    chk(out_valid_o == 1'b0, "R1", "valid after reset", 128'(out_valid_o), 128'd0);
  endtask

  task automatic t_single();
    fill_rand();
    send_pair(0, 1'b1, 1'b1);
    drain_wait();
  endtask

  task automatic t_max();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = 255;
        mb[i][j] = 255;
      end
    send_pair(0, 1'b1, 1'b0);  // R2 worst-case sum 260100
    drain_wait();
  endtask

  task automatic t_batch();
    int c0;
    c0 = cyc;
    for (int p = 0; p < 3; p++) begin
      fill_rand();
      send_pair(0, 1'b1, 1'b0);
    end
    drain_wait();
    // R5 final out_last for 3 pairs
    chk(last_cyc == c0 + 1 + 3 * N + N - 2, "R5", "batch end cycle",
        128'(last_cyc), 128'(c0 + 1 + 3 * N + N - 2));
  endtask

  task automatic t_gaps();
    fill_rand();
    send_pair(2, 1'b1, 1'b0);  // R6
    fill_rand();
    send_pair(1, 1'b1, 1'b0);  // R6
    drain_wait();
  endtask

  task automatic t_restart();
    fill_rand();
    beat(0, 1'b1);
    @(negedge clk_i);
    beat(1, 1'b0);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    fill_rand();
    send_pair(0, 1'b1, 1'b0);  // R7 only this pair is reported
    drain_wait();
  endtask

  task automatic t_implicit();
    fill_rand();
    send_pair(0, 1'b0, 1'b0);  // R8 no start flag at all
    fill_rand();
    send_pair(1, 1'b0, 1'b0);  // R8
    drain_wait();
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_max();
    t_batch();
    t_gaps();
    t_restart();
    t_implicit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule